// File: doc/BRIEF.md
# Seven-to-One Parallel-to-Serial Link Transmitter

This block turns a 28-bit parallel word into four serial lanes plus a forwarded clock lane. It is meant for a display-style link. A word is captured once per pixel clock. The capture happens on the rising edge or on the falling edge, as chosen by a static select input. The word is then split into four 7-bit slices. Each slice is shifted out on its own lane, one bit per cycle of a bit clock that runs at exactly seven times the pixel rate. A fifth lane sends a fixed 7-bit pattern for every word. That lane toggles at the pixel rate, so a receiver can find the word boundaries and rebuild each word exactly.

The 7x bit clock comes from outside the block. The pixel clock and the bit clock must be phase-related so that every seventh bit-clock cycle lines up with one pixel-clock period. The captured word crosses into the bit-clock domain through a double-registered toggle handoff. The first handoff event aligns a mod-7 slice counter. After that, the counter alone triggers a parallel load every seventh bit-clock cycle.

An active-low shutdown input clears every register at once and holds all five outputs low. After shutdown is released, the outputs stay low until the first whole word has been captured and loaded.

Top module: `ser7_link_tx`

## Requirements
- R1: With `edge_sel` = 0 the word is captured on the rising edge of `pclk`. With `edge_sel` = 1 it is captured on the falling edge. `edge_sel` is changed only while `shutdown_n` is low.
- R2: Lane k (`lane_out[k]`, k = 0..3) carries data bits 7k through 7k+6. Bit 7k+6 goes first and bit 7k goes last, with one bit per `bclk` cycle.
- R3: Once running, each word occupies exactly seven consecutive `bclk` cycles, and successive words follow with no gap. A parallel load happens on every seventh `bclk` cycle, in step with the pixel-clock captures.
- R4: For every word, `clk_lane_out` sends the pattern 1100011, first bit first. Its first bit falls in the same `bclk` cycle as the first bit of each data slice.
- R5: While `shutdown_n` is low, all four data lanes and the clock lane are 0. The outputs go to 0 as soon as `shutdown_n` falls, without waiting for a clock edge.
- R6: After `shutdown_n` rises, every output stays 0 until the first complete word has been loaded. The first word sent is the first word captured after the release, so no partial slice is ever driven.
- R7: The link is transparent. Rebuilding each 7-cycle group as {lane3, lane2, lane1, lane0} gives back the captured words in capture order, with none dropped and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; one word per period |
| bclk | input | 1 | Bit clock at seven times the pixel rate, phase-related to `pclk` |
| edge_sel | input | 1 | Capture edge: 0 = rising, 1 = falling |
| shutdown_n | input | 1 | Active-low shutdown; clears all state and silences outputs |
| data_in | input | 28 | Parallel data word, bits 0..27 |
| lane_out | output | 4 | Serial data lanes, one slice each |
| clk_lane_out | output | 1 | Forwarded pixel-rate clock lane |

## Verification
The bench runs the transmitter with each capture edge, using six word patterns. A walking one and a walking zero sweep all 28 bit positions, so any swapped lane, reversed slice or off-by-one slice boundary lands on the wrong bit. Alternating 0x5555555/0xAAAAAAA words and all-ones words flip every bit between neighbouring words, which shows whether a word is torn or held across a load. A lane-tagged pattern and a multiplicative-hash sequence give every word a distinct value, so a dropped, repeated or stale word shows up. In falling-edge mode the data changes on the rising edge, so capturing on the wrong edge returns the previous word. Each run ends with a shutdown in the middle of the stream, and each run starts with an idle-until-first-word check.

// File: rtl/ser7_pkg.sv
`timescale 1ns/100ps
package ser7_pkg;
    localparam int unsigned SER_SLICE_W = 7;
    localparam int unsigned SER_LANE_N  = 4;
    localparam int unsigned SER_SYNC_N  = 2;
    localparam logic [SER_SLICE_W-1:0] SER_FWD_PAT = 7'b1100011;
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/100ps
// Pixel-domain word capture on a selectable edge, with a toggle flag that
// announces each new word to the bit-clock domain.
module ser7_capture #(
    parameter int unsigned WORD_W = 28
) (
    input  logic              pclk,
    input  logic              edge_sel,
    input  logic              shutdown_n,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] word_q,
    output logic              tog_q
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              tog;
    } cap_t;

    cap_t cur_q, nxt_d;
    logic cap_clk;

    // Inverting the clock moves the capture to the falling edge; edge_sel
    // is static whenever the block runs.
    assign cap_clk = pclk ^ edge_sel;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.word = data_in;
        nxt_d.tog  = ~cur_q.tog;
    end

    always_ff @(posedge cap_clk or negedge shutdown_n) begin
        if (!shutdown_n) cur_q <= '0;
        else             cur_q <= nxt_d;
    end

    assign word_q = cur_q.word;
    assign tog_q  = cur_q.tog;
endmodule

// File: rtl/ser7_xfer_sync.sv
`timescale 1ns/100ps
// Brings the capture toggle into the bit-clock domain through SYNC_N
// registers and flags each change with one more stage.
module ser7_xfer_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic bclk,
    input  logic shutdown_n,
    input  logic tog_in,
    output logic evt
);
    typedef struct packed {
        logic [SYNC_N:0] chain;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[SYNC_N-1:0], tog_in};
    end

    always_ff @(posedge bclk or negedge shutdown_n) begin
        if (!shutdown_n) cur_q <= '0;
        else             cur_q <= nxt_d;
    end

    assign evt = cur_q.chain[SYNC_N-1] ^ cur_q.chain[SYNC_N];
endmodule

// File: rtl/ser7_load_seq.sv
`timescale 1ns/100ps
// Mod-SLICE_W slice counter. The first handoff event starts it; after that
// it alone decides the load cycle.
module ser7_load_seq #(
    parameter int unsigned SLICE_W = 7
) (
    input  logic bclk,
    input  logic shutdown_n,
    input  logic evt,
    output logic load,
    output logic run_q
);
    localparam int unsigned PH_W = $clog2(SLICE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLICE_W - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            run;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic ld_d;

    always_comb begin
        nxt_d = cur_q;
        ld_d  = cur_q.run ? (cur_q.phase == PH_LAST) : evt;
        if (ld_d) begin
            nxt_d.phase = '0;
            nxt_d.run   = 1'b1;
        end else if (cur_q.run) begin
            nxt_d.phase = cur_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge bclk or negedge shutdown_n) begin
        if (!shutdown_n) cur_q <= '0;
        else             cur_q <= nxt_d;
    end

    assign load  = ld_d;
    assign run_q = cur_q.run;

    // A fresh word from the pixel domain must arrive exactly at the last slot.
    AST_EVT_ON_LAST_SLOT: assert property (@(posedge bclk) disable iff (!shutdown_n)
        (cur_q.run && evt) |-> (cur_q.phase == PH_LAST)); // R3
    AST_NO_MISSED_WORD: assert property (@(posedge bclk) disable iff (!shutdown_n)
        (cur_q.run && cur_q.phase == PH_LAST) |-> evt); // R3
endmodule

// File: rtl/ser7_lane_shift.sv
`timescale 1ns/100ps
// One lane: parallel load, shift toward the MSB, MSB drives the line.
module ser7_lane_shift #(
    parameter int unsigned SLICE_W = 7
) (
    input  logic               bclk,
    input  logic               shutdown_n,
    input  logic               load,
    input  logic [SLICE_W-1:0] par_in,
    output logic               ser_out
);
    typedef struct packed {
        logic [SLICE_W-1:0] sh;
    } shf_t;

    shf_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) nxt_d.sh = par_in;
        else      nxt_d.sh = {cur_q.sh[SLICE_W-2:0], 1'b0};
    end

    always_ff @(posedge bclk or negedge shutdown_n) begin
        if (!shutdown_n) cur_q <= '0;
        else             cur_q <= nxt_d;
    end

    assign ser_out = cur_q.sh[SLICE_W-1];

    AST_SLICE_MSB_FIRST: assert property (@(posedge bclk) disable iff (!shutdown_n)
        load |=> (ser_out == $past(par_in[SLICE_W-1]))); // R2
endmodule

// File: rtl/ser7_link_tx.sv
`timescale 1ns/100ps
module ser7_link_tx
    import ser7_pkg::*;
#(
    parameter int unsigned         LANE_N  = SER_LANE_N,
    parameter int unsigned         SLICE_W = SER_SLICE_W,
    parameter int unsigned         SYNC_N  = SER_SYNC_N,
    parameter logic [SLICE_W-1:0]  FWD_PAT = SER_FWD_PAT
) (
    input  logic                        pclk,
    input  logic                        bclk,
    input  logic                        edge_sel,
    input  logic                        shutdown_n,
    input  logic [LANE_N*SLICE_W-1:0]   data_in,
    output logic [LANE_N-1:0]           lane_out,
    output logic                        clk_lane_out
);
    localparam int unsigned WORD_W = LANE_N * SLICE_W;

    logic [WORD_W-1:0] word_q;
    logic              tog_q;
    logic              evt;
    logic              load;
    logic              run_q;

    ser7_capture #(.WORD_W(WORD_W)) u_cap (
        .pclk       (pclk),
        .edge_sel   (edge_sel),
        .shutdown_n (shutdown_n),
        .data_in    (data_in),
        .word_q     (word_q),
        .tog_q      (tog_q)
    );

    ser7_xfer_sync #(.SYNC_N(SYNC_N)) u_sync (
        .bclk       (bclk),
        .shutdown_n (shutdown_n),
        .tog_in     (tog_q),
        .evt        (evt)
    );

    ser7_load_seq #(.SLICE_W(SLICE_W)) u_seq (
        .bclk       (bclk),
        .shutdown_n (shutdown_n),
        .evt        (evt),
        .load       (load),
        .run_q      (run_q)
    );

    // word_q is read in the bit domain only on a load. By then it has been
    // stable for SYNC_N+1 bit cycles, and it stays stable for several more.
    for (genvar k = 0; k < LANE_N; k++) begin : g_lane
        ser7_lane_shift #(.SLICE_W(SLICE_W)) u_sh (
            .bclk       (bclk),
            .shutdown_n (shutdown_n),
            .load       (load),
            .par_in     (word_q[k*SLICE_W +: SLICE_W]),
            .ser_out    (lane_out[k])
        );
    end

    ser7_lane_shift #(.SLICE_W(SLICE_W)) u_fwd (
        .bclk       (bclk),
        .shutdown_n (shutdown_n),
        .load       (load),
        .par_in     (FWD_PAT),
        .ser_out    (clk_lane_out)
    );

    AST_IDLE_UNTIL_RUN: assert property (@(posedge bclk) disable iff (!shutdown_n)
        !run_q |-> (lane_out == '0 && !clk_lane_out)); // R6
    AST_FWD_ALIGNED: assert property (@(posedge bclk) disable iff (!shutdown_n)
        load |=> (clk_lane_out == FWD_PAT[SLICE_W-1])); // R4

    always_ff @(posedge bclk) begin
        if (!shutdown_n) begin
            AST_SHUTDOWN_QUIET: assert (lane_out == '0 && !clk_lane_out); // R5
        end
    end
endmodule

// File: tb/ser7_link_tx_tb.sv
`timescale 1ns/100ps
module ser7_link_tx_tb;
    logic        pclk = 1'b0;
    logic        bclk = 1'b0;
    logic        edge_sel = 1'b0;
    logic        shutdown_n = 1'b1;
    logic [27:0] data_in = '0;
    logic [3:0]  lane_out;
    logic        clk_lane_out;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [27:0] exp_mem [0:63];
    int   wr_idx = 0;
    int   rd_idx = 0;
    logic mon_en = 1'b0;
    logic started = 1'b0;
    logic idle_bad = 1'b0;
    int   nbit = 0;
    logic [6:0] acc [4];
    logic [6:0] cacc;

    ser7_link_tx u_dut (
        .pclk         (pclk),
        .bclk         (bclk),
        .edge_sel     (edge_sel),
        .shutdown_n   (shutdown_n),
        .data_in      (data_in),
        .lane_out     (lane_out),
        .clk_lane_out (clk_lane_out)
    );

    // 200 MHz bit clock; pixel clock at 1/7, offset so no edges coincide.
    always #2.5 bclk = ~bclk;
    initial begin
        #1;
        forever begin
            pclk = 1'b1; #17.5;
            pclk = 1'b0; #17.5;
        end
    end

    // Bench model of the capture (R1): record the word at the selected edge.
    always @(posedge pclk) if (shutdown_n && !edge_sel && wr_idx < 64) begin
        exp_mem[wr_idx] = data_in; wr_idx++;
    end
    always @(negedge pclk) if (shutdown_n && edge_sel && wr_idx < 64) begin
        exp_mem[wr_idx] = data_in; wr_idx++;
    end

    // Deserializer: lane k holds bits 7k+6..7k MSB first; word starts with clock-lane 1.
    always @(negedge bclk) begin
        if (!mon_en) begin
            started = 1'b0; nbit = 0;
        end else if (!started) begin
            if (clk_lane_out) begin
                started = 1'b1;
                for (int k = 0; k < 4; k++) acc[k] = {6'b0, lane_out[k]};
                cacc = 7'b1; nbit = 1;
            end else if (lane_out != 4'b0) begin
                idle_bad = 1'b1;
            end
        end else begin
            for (int k = 0; k < 4; k++) acc[k] = {acc[k][5:0], lane_out[k]};
            cacc = {cacc[5:0], clk_lane_out};
            nbit++;
            if (nbit == 7) begin
                nbit = 0;
                check_word({acc[3], acc[2], acc[1], acc[0]});
                checks++;
                if (cacc != 7'b1100011) begin
                    fails++;
                    $display("FAIL R4 clock lane got %b exp 1100011", cacc);
                end
            end
        end
    end

    task automatic check_word(input logic [27:0] got);
        checks++;
        if (rd_idx >= wr_idx) begin
            fails++;
            $display("FAIL R7 extra word %0d got %h exp none", rd_idx, got);
        end else if (got != exp_mem[rd_idx]) begin
            fails++;
            $display("FAIL R1 R2 R7 word %0d edge_sel=%0d got %h exp %h",
                     rd_idx, edge_sel, got, exp_mem[rd_idx]);
        end
        rd_idx++;
    endtask

    task automatic chk(input logic ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic logic [27:0] pat(input int kind, input int i);
        logic [31:0] h;
        case (kind)
            0: pat = 28'h1 << (i % 28);
            1: pat = ~(28'h1 << (i % 28));
            2: pat = i[0] ? 28'hAAAAAAA : 28'h5555555;
            3: pat = i[0] ? 28'hFFFFFFF : 28'h0000000;
            4: pat = {3'd3, i[3:0], 3'd2, i[3:0], 3'd1, i[3:0], 3'd0, i[3:0]};
            default: begin
                h = (i + 1) * 32'h9E3779B1;
                pat = h[31:4];
            end
        endcase
    endfunction

    task automatic run_phase(input logic esel, input int kind, input int n);
        edge_sel = esel;
        repeat (4) @(negedge bclk);
        wr_idx = 0; rd_idx = 0; idle_bad = 1'b0;
        @(negedge bclk); #2;
        shutdown_n = 1'b1; mon_en = 1'b1;
        for (int i = 0; i < n + 4; i++) begin
            if (esel) @(posedge pclk);
            else      @(negedge pclk);
            #1 data_in = pat(kind, i);
        end
        repeat (20) @(negedge bclk);
        chk(rd_idx >= n, "R3 words received back-to-back", rd_idx, n);
        chk(!idle_bad, "R6 idle before first word", int'(idle_bad), 0);
        // Mid-stream shutdown: outputs drop at once (R5).
        @(negedge bclk); #2;
        mon_en = 1'b0; shutdown_n = 1'b0;
        #1;
        chk(lane_out == 4'b0 && !clk_lane_out, "R5 outputs after shutdown",
            int'({lane_out, clk_lane_out}), 0);
    endtask

    initial begin
        #0.5 shutdown_n = 1'b0;
        repeat (6) @(negedge bclk);
        chk(lane_out == 4'b0 && !clk_lane_out, "R5 reset state",
            int'({lane_out, clk_lane_out}), 0);
        for (int e = 0; e < 2; e++) begin
            for (int kind = 0; kind < 6; kind++) begin
                run_phase(e[0], kind, (kind < 2) ? 28 : 16);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge bclk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog run did not finish got 0 exp 1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule